// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sequences single read and write accesses on a multiplexed 16-bit address/data bus. An access passes through five fixed bus states, T1 to T5. Extra wait states can be placed after T2 to stretch the cycle for slow devices. The address goes out first and is marked by an address-hold strobe. The same lines then carry the data: the block drives them for a write, and releases them for a read so the device can drive them.

The number of wait states comes from a 2-bit programmed field. Each address area has its own field, and the field used is chosen by the area code given with the request. In program-wait mode exactly the programmed count is inserted. In the pin-driven modes the programmed count is inserted first. An active-low wait input is then sampled on the falling clock edge of each final pre-strobe state, and every low sample adds one more wait state. Request inputs are captured when the request is accepted, so the requester may change them during the access.

Top module: `ext_bus_wait_seq`

## Requirements
- R1: An accepted access occupies exactly 5+N cycles in the order T1, T2, N wait states, T3, T4, T5, where N is the number of wait states; the block then returns to idle.
- R2: `ah_o` is high only in T1. In T1 and T2 the bus is driven (`ad_oe_o`=1) with the captured address.
- R3: The wait field is selected by `area_i`. Code 0 selects `wc_fields_i[1:0]`, code 1 selects `[3:2]` and code 2 selects `[5:4]`. Code 3 falls back to `[1:0]`.
- R4: When `mode_i` is 0 or 3 (program wait), N equals the selected field, and `wait_ni` has no effect on the cycle.
- R5: When `mode_i` is 1 or 2 (pin wait), the field's waits come first. After that, `wait_ni` is sampled on the falling edge of the last T2 or wait state, and each low sample adds one wait state.
- R6: A read raises `rd_o` during T3 and T4 only, never drives the bus after T2, and captures `ad_i` into `rdata_o` at the end of T4.
- R7: A write raises `wr_o` during T3 and T4 only, and drives the captured write data from T3 through T5. A write leaves `rdata_o` unchanged.
- R8: `done_o` is high for exactly one cycle, during T5.
- R9: Requests are accepted only in idle. Address, data, direction, area, field values and mode are captured at acceptance, and changes after that have no effect on the running access.
- R10: After reset and while idle, all strobes, `done_o` and `ad_oe_o` are low, and `rdata_o` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken in idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Access address |
| wdata_i | input | 16 | Write data |
| area_i | input | 2 | Address area code |
| wc_fields_i | input | 6 | Packed 2-bit wait counts, one per area |
| mode_i | input | 2 | 0/3 program wait, 1/2 pin wait |
| wait_ni | input | 1 | External wait request, active low |
| ad_i | input | 16 | Bus value read back from the pads |
| ah_o | output | 1 | Address-hold strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| ad_oe_o | output | 1 | Bus output enable |
| ad_o | output | 16 | Bus drive value |
| rdata_o | output | 16 | Captured read data |
| done_o | output | 1 | Access complete pulse |

## Verification
The running count of programmed waits and the falling-edge sample of the wait input can meet in the same state. When the count reaches zero in T2 or a wait state, a low sample taken in that same state has to add a wait state. The bench provokes this by holding `wait_ni` low for K cycles from T1, across every field value, area and mode. It predicts N = field + max(0, K-1-field) in the pin modes and N = field in program mode, and judges the result cycle by cycle through the strobe, enable and bus pattern.

// File: rtl/ext_bus_wait_pkg.sv
package ext_bus_wait_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4, S_T5
  } bus_state_e;

  localparam logic [1:0] MODE_PROG  = 2'd0;
  localparam logic [1:0] MODE_PIN   = 2'd1;
  localparam logic [1:0] MODE_BOTH  = 2'd2;
endpackage

// File: rtl/ext_bus_area_sel.sv
module ext_bus_area_sel #(
  parameter int N_AREA = 3,
  parameter int WC_W   = 2,
  localparam int AREA_W = (N_AREA > 1) ? $clog2(N_AREA + 1) : 1
) (
  input  logic [AREA_W-1:0]      area_i,
  input  logic [N_AREA*WC_W-1:0] fields_i,
  output logic [WC_W-1:0]        wc_o
);
  // unmapped area codes fall back to area 0
  always_comb begin
    wc_o = fields_i[WC_W-1:0];
    for (int a = 1; a < N_AREA; a++) begin
      if (area_i == AREA_W'(a)) wc_o = fields_i[a*WC_W +: WC_W];
    end
  end
endmodule

// File: rtl/ext_bus_wait_sampler.sv
module ext_bus_wait_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_ni,
  output logic wait_low_o
);
  logic wait_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= 1'b1;
    else         wait_q <= wait_ni;
  end

  assign wait_low_o = ~wait_q;
endmodule

// File: rtl/ext_bus_seq_fsm.sv
module ext_bus_seq_fsm
  import ext_bus_wait_pkg::*;
#(
  parameter int WC_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [WC_W-1:0] wc_i,
  input  logic            pin_en_i,
  input  logic            wait_low_i,
  output bus_state_e      state_o,
  output logic            accept_o
);
  bus_state_e      state_q, state_d;
  logic [WC_W-1:0] cnt_q;
  logic            pin_q;
  logic            cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept_o = (state_q == S_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (req_i) state_d = S_T1;
      S_T1:      state_d = S_T2;
      S_T2, S_TW: begin
        if (!cnt_zero)                state_d = S_TW;
        else if (pin_q && wait_low_i) state_d = S_TW;
        else                          state_d = S_T3;
      end
      S_T3:      state_d = S_T4;
      S_T4:      state_d = S_T5;
      S_T5:      state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      pin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        cnt_q <= wc_i;
        pin_q <= pin_en_i;
      end else if ((state_q == S_T2 || state_q == S_TW) && !cnt_zero) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/ext_bus_wait_seq.sv
module ext_bus_wait_seq
  import ext_bus_wait_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_AREA = 3,
  parameter int WC_W   = 2,
  localparam int AREA_W = (N_AREA > 1) ? $clog2(N_AREA + 1) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [ADDR_W-1:0]      wdata_i,
  input  logic [AREA_W-1:0]      area_i,
  input  logic [N_AREA*WC_W-1:0] wc_fields_i,
  input  logic [1:0]             mode_i,
  input  logic                   wait_ni,
  input  logic [ADDR_W-1:0]      ad_i,
  output logic                   ah_o,
  output logic                   rd_o,
  output logic                   wr_o,
  output logic                   ad_oe_o,
  output logic [ADDR_W-1:0]      ad_o,
  output logic [ADDR_W-1:0]      rdata_o,
  output logic                   done_o
);
  bus_state_e        state;
  logic              accept;
  logic [WC_W-1:0]   wc_sel;
  logic              wait_low;
  logic              pin_en;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q, wdata_q, rdata_q;
  logic              addr_ph, strobe_ph, data_ph;

  assign pin_en = (mode_i == MODE_PIN) || (mode_i == MODE_BOTH);

  ext_bus_area_sel #(.N_AREA(N_AREA), .WC_W(WC_W)) u_area_sel (
    .area_i  (area_i),
    .fields_i(wc_fields_i),
    .wc_o    (wc_sel)
  );

  ext_bus_wait_sampler u_wait_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wait_ni   (wait_ni),
    .wait_low_o(wait_low)
  );

  ext_bus_seq_fsm #(.WC_W(WC_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .wc_i      (wc_sel),
    .pin_en_i  (pin_en),
    .wait_low_i(wait_low),
    .state_o   (state),
    .accept_o  (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (state == S_T4 && !we_q) rdata_q <= ad_i;
    end
  end

  assign addr_ph   = (state == S_T1) || (state == S_T2);
  assign strobe_ph = (state == S_T3) || (state == S_T4);
  assign data_ph   = strobe_ph || (state == S_T5);

  assign ah_o    = (state == S_T1);
  assign rd_o    = strobe_ph && !we_q;
  assign wr_o    = strobe_ph && we_q;
  assign ad_oe_o = addr_ph || (data_ph && we_q);
  assign ad_o    = addr_ph ? addr_q : wdata_q;
  assign done_o  = (state == S_T5);
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ext_bus_wait_seq_chk.sv
module ext_bus_wait_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ah_o,
  input logic rd_o,
  input logic wr_o,
  input logic ad_oe_o,
  input logic done_o
);
  assert_ah_then_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ah_o |=> !ah_o && ad_oe_o && !rd_o && !wr_o);

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  assert_rd_two_cycles_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_o) |=> rd_o);

  assert_rd_bus_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !ad_oe_o);

  assert_wr_drives_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ad_oe_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !ah_o);

  assert_strobe_end_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_o || wr_o) |-> done_o);
endmodule

bind ext_bus_wait_seq ext_bus_wait_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ah_o   (ah_o),
  .rd_o   (rd_o),
  .wr_o   (wr_o),
  .ad_oe_o(ad_oe_o),
  .done_o (done_o)
);

// File: tb/ext_bus_wait_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_wait_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, wait_ni = 1'b1;
  logic [15:0] addr_i = '0, wdata_i = '0, ad_i = '0;
  logic [1:0]  area_i = '0, mode_i = '0;
  logic [5:0]  wc_fields_i = '0;
  logic        ah_o, rd_o, wr_o, ad_oe_o, done_o;
  logic [15:0] ad_o, rdata_o;

  int errs = 0;
  int checks = 0;
  logic [15:0] prev_rdata = '0;

  always #5 clk_i = ~clk_i;

  ext_bus_wait_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .area_i(area_i),
    .wc_fields_i(wc_fields_i), .mode_i(mode_i), .wait_ni(wait_ni),
    .ad_i(ad_i), .ah_o(ah_o), .rd_o(rd_o), .wr_o(wr_o),
    .ad_oe_o(ad_oe_o), .ad_o(ad_o), .rdata_o(rdata_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] outv();
    return {11'd0, ah_o, rd_o, wr_o, ad_oe_o, done_o, (ad_oe_o ? ad_o : 16'h0)};
  endfunction

  // one access; K = cycles from T1 that wait_ni is held low
  task automatic access(input logic we, input logic [1:0] area, input logic [1:0] mode,
                        input logic [5:0] fields, input int k,
                        input logic [15:0] addr, input logic [15:0] wdata);
    int wc, nw, last;
    logic pin;
    logic [31:0] exp;
    logic [15:0] expd;
    bit ah, rd, wr, oe, dn;
    wc  = (area == 2'd1) ? int'(fields[3:2]) : (area == 2'd2) ? int'(fields[5:4]) : int'(fields[1:0]);
    pin = (mode == 2'd1) || (mode == 2'd2);
    nw  = wc + ((pin && (k - 1 - wc) > 0) ? (k - 1 - wc) : 0);
    last = 4 + nw;
    // idle check (R10)
    @(negedge clk_i); #2;
    chk("R10 idle outputs", outv(), 32'h0);
    @(posedge clk_i); #1;
    req_i = 1'b1; we_i = we; addr_i = addr; wdata_i = wdata; area_i = area;
    mode_i = mode; wc_fields_i = fields; ad_i = addr ^ 16'h5A5A; wait_ni = 1'b1;
    @(posedge clk_i); #1;
    for (int i = 0; i <= last; i++) begin
      // scramble request inputs while busy (R9)
      addr_i = ~addr; wdata_i = ~wdata; we_i = ~we; area_i = area + 2'd1;
      mode_i = ~mode; wc_fields_i = ~fields;
      wait_ni = (i < k) ? 1'b0 : 1'b1;
      req_i = (i < last);
      @(negedge clk_i); #2;
      ah = (i == 0);
      rd = !we && (i == 2 + nw || i == 3 + nw);
      wr = we && (i == 2 + nw || i == 3 + nw);
      oe = (i <= 1) || (we && i >= 2 + nw);
      dn = (i == last);
      expd = oe ? ((i <= 1) ? addr : wdata) : 16'h0;
      exp = {11'd0, ah, rd, wr, oe, dn, expd};
      chk(pin ? "R1 R2 R3 R5 R6 R7 R8 R9 cycle" : "R1 R2 R3 R4 R6 R7 R8 R9 cycle", outv(), exp);
      @(posedge clk_i); #1;
    end
    req_i = 1'b0; wait_ni = 1'b1;
    @(negedge clk_i); #2;
    if (!we) prev_rdata = addr ^ 16'h5A5A;
    chk(we ? "R7 rdata kept" : "R6 rdata capture", {16'h0, rdata_o}, {16'h0, prev_rdata});
    chk("R1 back to idle", outv(), 32'h0);
  endtask

  initial begin
    #1_500_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #12;
    chk("R10 reset outputs", outv(), 32'h0);
    chk("R10 reset rdata", {16'h0, rdata_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 4; a++)
        for (int f = 0; f < 4; f++)
          for (int k = 0; k <= 6; k++)
            for (int w = 0; w < 2; w++)
              access(w[0], a[1:0], m[1:0],
                     {2'((f + 2) % 4), 2'((f + 1) % 4), 2'(f % 4)}, k,
                     16'(16'h1000 + m * 16'h0300 + a * 16'h0040 + f * 16'h0008 + k),
                     16'(16'hC000 ^ (m * 16'h0111 + a * 16'h0022 + f * 16'h0005 + k * 16'h0103)));
    // long pin-wait stretch well beyond four waits (R5)
    access(1'b0, 2'd0, 2'd1, 6'b00_00_11, 12, 16'hBEEF, 16'h0);
    access(1'b1, 2'd2, 2'd2, 6'b00_00_00, 10, 16'h1234, 16'hA5C3);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule